// File: doc/BRIEF.md
# Fractional Tick Prescaler

This block generates one shared tick strobe for a group of pulse channels. One of three source enables is picked by a 2-bit select code. The block then divides the selected enable stream by a ratio made of an integral part and a fractional part. All sources are modelled as clock enables inside one system clock domain, so the selection is a plain multiplexer on enables and not a clock switch.

The integral field holds the wanted whole divisor minus one. The fraction is a numerator over a denominator. An accumulator spreads the fraction over successive periods: now and then a period is one source cycle longer, so the long-run tick rate is the source rate divided by (1 + integral + numerator/denominator). A configuration active bit gates the output. Software clears it before it changes any divider or select field and sets it again afterwards. Each rise of the bit starts a clean division run.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first qualifying source cycle, `tick` is low.
- R2: Select code 1 uses `src_en[0]`, code 2 uses `src_en[1]` and code 3 uses `src_en[2]`. Code 0 selects no source and gives no ticks. Enables of sources that are not selected have no effect on `tick`.
- R3: When the fraction is off, `tick` fires once for every `cfg_int`+1 cycles in which the selected enable is high. With a continuous enable and `cfg_int`=3, that gives 10 ticks in 40 cycles.
- R4: When 0 < `cfg_num` < `cfg_den`, the numerator is added to an accumulator at the end of each period. A period that ends with the sum at or above the denominator subtracts the denominator and makes the next period one enabled cycle longer. With a continuous enable, `cfg_int`=1, `cfg_num`=1 and `cfg_den`=2, that gives 16 ticks in 40 cycles.
- R5: A zero numerator, a zero denominator, or a numerator not below the denominator turns the fraction off. The block then behaves exactly as in R3.
- R6: While `cfg_active` is low no tick is produced and the division state is held at zero. After `cfg_active` rises, the first tick follows `cfg_int`+1 enabled cycles.
- R7: `tick` is high for one clock cycle. It is high in the cycle after the edge at which the selected enable completed a period, and it is never high unless the selected enable and `cfg_active` were high in the previous cycle.
- R8: Cycles in which the selected enable is low do not advance the division. With the enable high on every other cycle, `cfg_int`=2 and no fraction, 40 cycles give 6 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_en | input | N_SRC (3) | Per-source cycle enables; bit i is source code i+1 |
| cfg_active | input | 1 | Divider run enable; low while settings change |
| cfg_sel | input | SEL_W (2) | Source select code, 0 means none |
| cfg_int | input | INT_W (8) | Whole divisor minus one |
| cfg_num | input | FRAC_W (6) | Fraction numerator |
| cfg_den | input | FRAC_W (6) | Fraction denominator |
| tick | output | 1 | One-cycle tick strobe |

## Verification
Two things can land on the same enabled cycle: the terminal count that ends a period and the accumulator wrap that lengthens the next period. Both are also exposed to `cfg_active` falling on the very edge where a tick would fire. The bench provokes these coincidences with fractional ratios over a continuous enable, and with random enables and random settings applied between deactivation and reactivation. A cycle-accurate reference model in the bench judges each one. Directed windows with hand-counted tick totals pin the extra-cycle placement and the restart point after `cfg_active` rises.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  // source select codes; code k (k>0) picks enable bit k-1
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_RC   = 2'd2,
    SRC_XTAL = 2'd3
  } src_code_e;

  localparam int unsigned DEF_N_SRC  = 3;
  localparam int unsigned DEF_INT_W  = 8;
  localparam int unsigned DEF_FRAC_W = 6;
endpackage

// File: rtl/ftk_src_mux.sv
module ftk_src_mux #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_SRC-1:0] src_en,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_en
);
  logic [N_SRC-1:0] hit;

  // each source matches its own nonzero code; code 0 matches nothing
  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_hit
    assign hit[gi] = src_en[gi] & (sel == SEL_W'(gi + 1));
  end

  assign sel_en = |hit;
endmodule

// File: rtl/ftk_div_core.sv
module ftk_div_core #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 6,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sen,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              tick,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [FRAC_W-1:0] acc_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, last;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum, diff;
  logic              extra_q, extra_d;
  logic              tick_q, fire, frac_on, upd_en;

  always_comb begin
    frac_on = (num < den);
    last    = {1'b0, int_div} + {{INT_W{1'b0}}, extra_q};
    fire    = active & sen & (cnt_q == last);
    sum     = {1'b0, acc_q} + {1'b0, num};
    diff    = sum - {1'b0, den};
    upd_en  = ~active | sen;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    extra_d = extra_q;
    if (!active) begin
      cnt_d   = '0;
      acc_d   = '0;
      extra_d = 1'b0;
    end else if (sen) begin
      if (cnt_q == last) begin
        cnt_d = '0;
        if (frac_on && (sum >= {1'b0, den})) begin
          acc_d   = diff[FRAC_W-1:0];
          extra_d = 1'b1;
        end else if (frac_on) begin
          acc_d   = sum[FRAC_W-1:0];
          extra_d = 1'b0;
        end else begin
          acc_d   = '0;
          extra_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      extra_q <= extra_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= fire;
  end

  assign tick  = tick_q;
  assign cnt_o = cnt_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int unsigned N_SRC  = DEF_N_SRC,
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned SEL_W = $clog2(N_SRC + 1),
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_en,
  input  logic              cfg_active,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  output logic              tick
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              sel_en;
  logic [CNT_W-1:0]  core_cnt;
  logic [FRAC_W-1:0] core_acc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ftk_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
    .src_en (src_en),
    .sel    (cfg_sel),
    .sel_en (sel_en)
  );

  ftk_div_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .active  (cfg_active),
    .sen     (sel_en),
    .int_div (cfg_int),
    .num     (cfg_num),
    .den     (cfg_den),
    .tick    (tick),
    .cnt_o   (core_cnt),
    .acc_o   (core_acc)
  );
endmodule

// File: rtl/frac_tick_chk.sv
module frac_tick_chk #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 6,
  localparam int unsigned SEL_W = $clog2(N_SRC + 1),
  localparam int unsigned CNT_W = INT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_en,
  input logic              cfg_active,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [INT_W-1:0]  cfg_int,
  input logic [FRAC_W-1:0] cfg_num,
  input logic [FRAC_W-1:0] cfg_den,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [FRAC_W-1:0] acc
);
  logic chk_sen;
  always_comb begin
    chk_sen = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (cfg_sel == SEL_W'(i + 1)) chk_sen = src_en[i];
  end

  // R7
  tick_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(chk_sen));

  // R6
  tick_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(cfg_active));

  // R2
  no_tick_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(cfg_sel) != '0));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |=> (cnt == '0 && acc == '0));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_active |-> (cnt <= ({1'b0, cfg_int} + 1'b1)));

  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && (cfg_num < cfg_den)) |-> (acc < cfg_den));
endmodule

bind frac_tick_gen frac_tick_chk #(.N_SRC(N_SRC), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_en     (src_en),
  .cfg_active (cfg_active),
  .cfg_sel    (cfg_sel),
  .cfg_int    (cfg_int),
  .cfg_num    (cfg_num),
  .cfg_den    (cfg_den),
  .tick       (tick),
  .cnt        (core_cnt),
  .acc        (core_acc)
);

// File: tb/test_frac_tick_gen.sv
`timescale 1ns/1ps
module test_frac_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] src_en;
  logic       cfg_active;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_int;
  logic [5:0] cfg_num, cfg_den;
  logic       tick;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 0, done = 0;
  string tag = "R1";

  // reference model state
  int m_cnt, m_acc, m_extra;
  bit exp_tick;

  always #5 clk = ~clk;

  frac_tick_gen i_frac_tick_gen (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .cfg_active(cfg_active),
    .cfg_sel(cfg_sel), .cfg_int(cfg_int), .cfg_num(cfg_num),
    .cfg_den(cfg_den), .tick(tick)
  );

  function automatic bit model_sen(input logic [1:0] s, input logic [2:0] e);
    return (s == 2'd0) ? 1'b0 : e[s - 1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_extra = 0; exp_tick = 0;
    end else begin
      bit s; int lst; bit f;
      s   = model_sen(cfg_sel, src_en);
      lst = int'(cfg_int) + m_extra;
      f   = cfg_active && s && (m_cnt == lst);
      if (!cfg_active) begin
        m_cnt = 0; m_acc = 0; m_extra = 0;
      end else if (s) begin
        if (m_cnt == lst) begin
          m_cnt = 0;
          if (cfg_num < cfg_den) begin
            m_acc += int'(cfg_num);
            if (m_acc >= int'(cfg_den)) begin m_acc -= int'(cfg_den); m_extra = 1; end
            else m_extra = 0;
          end else begin m_acc = 0; m_extra = 0; end
        end else m_cnt++;
      end
      exp_tick = f;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      checks++;
      if (tick !== exp_tick) begin
        fails++;
        $display("FAIL %s cycle %0d: tick actual %0b expected %0b", tag, cyc, tick, exp_tick);
      end
    end
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int s, input int n, input int a, input int b);
    @(negedge clk);
    cfg_active = 0;
    @(negedge clk);
    cfg_sel = 2'(s); cfg_int = 8'(n); cfg_num = 6'(a); cfg_den = 6'(b);
    @(negedge clk);
    cfg_active = 1;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  initial begin
    int c;
    rst_n = 0; src_en = '0; cfg_active = 0; cfg_sel = 0;
    cfg_int = 0; cfg_num = 0; cfg_den = 0;
    repeat (3) @(negedge clk);
    check("R1", tick, 0);
    rst_n = 1;
    src_en = 3'b111; cfg_sel = 1;
    repeat (4) @(negedge clk);
    check("R1", tick, 0);
    cmp_on = 1;

    tag = "R3"; setup(1, 3, 0, 0); count_ticks(40, c); check("R3", c, 10);
    tag = "R4"; setup(1, 1, 1, 2); count_ticks(40, c); check("R4", c, 16);
    tag = "R5"; setup(1, 1, 3, 2); count_ticks(40, c); check("R5", c, 20);
    setup(1, 1, 0, 5); count_ticks(40, c); check("R5", c, 20);
    setup(1, 1, 4, 0); count_ticks(40, c); check("R5", c, 20);

    tag = "R2"; setup(0, 0, 0, 0); count_ticks(40, c); check("R2", c, 0);
    src_en = 3'b101; setup(2, 0, 0, 0); count_ticks(40, c); check("R2", c, 0);
    src_en = 3'b100; setup(3, 0, 0, 0); count_ticks(40, c); check("R2", c, 40);
    src_en = 3'b010; setup(2, 1, 0, 0); count_ticks(40, c); check("R2", c, 20);

    tag = "R6"; src_en = 3'b111;
    setup(1, 4, 0, 0);
    @(negedge clk); cfg_active = 0;
    count_ticks(20, c); check("R6", c, 0);
    setup(1, 4, 0, 0);
    repeat (7) @(negedge clk);
    cfg_active = 0; repeat (3) @(negedge clk);
    cfg_active = 1;
    c = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (tick && c == 0) c = i;
    end
    check("R6", c, 5);

    tag = "R8"; setup(1, 2, 0, 0);
    c = 0;
    for (int i = 0; i < 40; i++) begin
      src_en = (i % 2 == 0) ? 3'b001 : 3'b000;
      @(negedge clk);
      if (tick) c++;
    end
    check("R8", c, 6);

    tag = "R7"; src_en = 3'b111; setup(1, 5, 3, 7);
    c = 0;
    begin
      bit prev = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (tick && prev) c++;
        prev = tick;
      end
    end
    check("R7", c, 0);

    tag = "R4 random";
    void'($urandom(1234));
    for (int k = 0; k < 25; k++) begin
      setup($urandom_range(0, 3), $urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 7));
      for (int j = 0; j < 150; j++) begin
        src_en = {($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 7)};
        @(negedge clk);
      end
    end

    cmp_on = 0; done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule